// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator with Three Request Lines

This block collects nine external interrupt sources and presents them to a host interrupt controller as three request outputs. Each source is first brought into the clock domain by a two-stage synchronizer. It is then converted to an "active" flag according to a per-source polarity bit and recorded in a pending vector. The pending vector is one set of bits shared by all outputs. Each output line has its own nine enable bits. A line asserts while any pending source that is enabled on it exists.

Software reaches the block through a simple single-cycle register port with a 4-bit word address, 32-bit write data, a write strobe and combinational read data. Word 0 holds the polarity bits. Words 1, 2 and 3 are the registers of lines 0, 1 and 2. Each of these line registers combines the enable bits of its line (low field) with a view of the shared pending vector (high field). A one written into the high field acknowledges the matching source. A single write can therefore mask a source and acknowledge it together.

Top module: `irq_aggregator`

## Requirements
- R1: While reset is asserted and after its release with all sources held high, every register reads 0 and all three request outputs are 0. The synchronizer resets to the inactive level for polarity 0.
- R2: Word address 0 holds the polarity bits: write data bits [8:0] are stored, and a read returns them in bits [8:0] with bits [31:9] zero.
- R3: Word addresses 4 to 15 read as zero, and writes to them change no register.
- R4: With polarity bit n = 0, source n is pending when its input is low. With polarity bit n = 1, source n is pending when its input is high.
- R5: Word addresses 1, 2 and 3 (lines 0, 1, 2) all return the same pending vector in bits [24:16], with source n at bit 16+n. Bits [8:0] of each return that line's enable bits.
- R6: A pending bit stays set after its source goes inactive. Writing 1 to bit 16+n of any line register clears pending bit n if source n is inactive. Writing 0 there leaves the bit unchanged.
- R7: A pending bit that is acknowledged while its source is still active stays set.
- R8: Request output k is registered: it equals, one clock later, the OR over n of pending[n] AND enable bit n of line k.
- R9: A pending source whose enable bit on line k is 0 does not drive output k, and it is still reported as pending.
- R10: One line-register write that clears enable bit n and sets bit 16+n both masks and acknowledges source n in the same clock.
- R11: Writing 0x01FF0000 to each of the three line registers clears every pending bit of inactive sources and every enable bit.
- R12: A change on a source input reaches its pending bit on the third rising clock edge after the change, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 9 | Asynchronous interrupt source levels |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | 4 | Word address of the register port |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the word at addr_i (combinational) |
| irq_o | output | 3 | Active-high request outputs, one per line |

## Verification
The bench builds the block with its default parameters: nine sources, three lines, a 32-bit data word and the pending field at bit 16. With these values the full address space is reachable, including the twelve unmapped words, and sources are routed to more than one line at once. Both polarities, the three-edge input latency and the one-edge output latency can then be checked against exact cycle counts. The acknowledge corner cases, where the source is still active or masking and acknowledge come in one write, are driven through different line registers so that the shared pending vector is observed from every view.

// File: rtl/irqagg_pkg.sv
`timescale 1ns/1ps
package irqagg_pkg;
    localparam int unsigned SRC_N    = 9;
    localparam int unsigned LINE_N   = 3;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ADDR_W   = 4;
    localparam int unsigned PEND_POS = 16;

    typedef enum logic [1:0] {
        SEL_POL,
        SEL_LINE,
        SEL_NONE
    } reg_sel_e;
endpackage

// File: rtl/irqagg_sync.sv
`timescale 1ns/1ps
// Two-stage synchronizer for a vector of asynchronous levels.
module irqagg_sync #(
    parameter int unsigned W = 9,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.s2;
endmodule

// File: rtl/irqagg_pend.sv
`timescale 1ns/1ps
// Polarity conversion and shared pending vector with acknowledge.
module irqagg_pend #(
    parameter int unsigned N = 9
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] lvl_i,
    input  logic [N-1:0] pol_i,
    input  logic [N-1:0] ack_i,
    output logic [N-1:0] active_o,
    output logic [N-1:0] pend_o
);
    typedef struct packed {
        logic [N-1:0] pend;
    } pend_t;

    pend_t st_d, st_q;

    for (genvar n = 0; n < N; n++) begin : g_act
        // polarity 1: high is active; polarity 0: low is active
        assign active_o[n] = pol_i[n] ? lvl_i[n] : ~lvl_i[n];
    end

    always_comb begin
        st_d      = st_q;
        // a still-active source wins over its acknowledge
        st_d.pend = (st_q.pend & ~ack_i) | active_o;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/irqagg_out.sv
`timescale 1ns/1ps
// Registered request outputs, one per line.
module irqagg_out #(
    parameter int unsigned N = 9,
    parameter int unsigned L = 3
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [N-1:0]   pend_i,
    input  logic [L*N-1:0] en_i,
    output logic [L-1:0]   irq_o
);
    typedef struct packed {
        logic [L-1:0] irq;
    } out_t;

    out_t st_d, st_q;
    logic [L-1:0] hit;

    for (genvar k = 0; k < L; k++) begin : g_line
        assign hit[k] = |(pend_i & en_i[k*N +: N]);
    end

    always_comb begin
        st_d     = st_q;
        st_d.irq = hit;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/irq_aggregator.sv
`timescale 1ns/1ps
module irq_aggregator
    import irqagg_pkg::*;
#(
    parameter int unsigned NSRC  = SRC_N,
    parameter int unsigned NLINE = LINE_N,
    parameter int unsigned DW    = DATA_W,
    parameter int unsigned AW    = ADDR_W,
    parameter int unsigned PPOS  = PEND_POS
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] src_i,
    input  logic            wr_en_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [DW-1:0]   wdata_i,
    output logic [DW-1:0]   rdata_o,
    output logic [NLINE-1:0] irq_o
);
    localparam int unsigned LIDX_W = (NLINE > 1) ? $clog2(NLINE) : 1;
    // idle level for the reset polarity (0 = active-low) is high
    localparam logic [NSRC-1:0] SYNC_RST = '1;

    typedef struct packed {
        logic [NSRC-1:0]              pol;
        logic [NLINE-1:0][NSRC-1:0]   en;
    } cfg_t;

    cfg_t              cfg_d, cfg_q;
    reg_sel_e          sel;
    logic [LIDX_W-1:0] lidx;
    logic [NSRC-1:0]   lvl_w, act_w, pend_w, ack_w, pol_w;
    logic [NLINE*NSRC-1:0] en_w;

    // address decode
    always_comb begin
        sel  = SEL_NONE;
        lidx = '0;
        if (addr_i == '0) begin
            sel = SEL_POL;
        end else if (int'(addr_i) <= int'(NLINE)) begin
            sel  = SEL_LINE;
            lidx = LIDX_W'(int'(addr_i) - 1);
        end
    end

    // configuration next state and acknowledge vector
    always_comb begin
        cfg_d = cfg_q;
        ack_w = '0;
        if (wr_en_i) begin
            case (sel)
                SEL_POL: cfg_d.pol = wdata_i[NSRC-1:0];
                SEL_LINE: begin
                    cfg_d.en[lidx] = wdata_i[NSRC-1:0];
                    ack_w          = wdata_i[PPOS +: NSRC];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // read path
    always_comb begin
        rdata_o = '0;
        case (sel)
            SEL_POL:  rdata_o = DW'(cfg_q.pol);
            SEL_LINE: rdata_o = (DW'(pend_w) << PPOS) | DW'(cfg_q.en[lidx]);
            default:  rdata_o = '0;
        endcase
    end

    assign pol_w = cfg_q.pol;
    assign en_w  = cfg_q.en;

    irqagg_sync #(
        .W       (NSRC),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (src_i),
        .q_o    (lvl_w)
    );

    irqagg_pend #(
        .N (NSRC)
    ) u_pend (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .lvl_i    (lvl_w),
        .pol_i    (pol_w),
        .ack_i    (ack_w),
        .active_o (act_w),
        .pend_o   (pend_w)
    );

    irqagg_out #(
        .N (NSRC),
        .L (NLINE)
    ) u_out (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pend_i (pend_w),
        .en_i   (en_w),
        .irq_o  (irq_o)
    );
endmodule

// File: rtl/irqagg_chk.sv
`timescale 1ns/1ps
module irqagg_chk #(
    parameter int unsigned N  = 9,
    parameter int unsigned L  = 3,
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 32,
    parameter int unsigned PP = 16
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic           wr_en_i,
    input logic [AW-1:0]  addr_i,
    input logic [DW-1:0]  wdata_i,
    input logic [DW-1:0]  rdata_o,
    input logic [L-1:0]   irq_o,
    input logic [N-1:0]   pol_w,
    input logic [N-1:0]   pend_w,
    input logic [N-1:0]   act_w
);
    logic line_addr;
    assign line_addr = (int'(addr_i) >= 1) && (int'(addr_i) <= int'(L));

    // R2: polarity write lands in the register
    a_r2_pol_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == '0) |=> (pol_w == $past(wdata_i[N-1:0])));

    // R3: unmapped words read zero
    a_r3_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(addr_i) > int'(L)) |-> (rdata_o == '0));

    // R5: every line view shows the shared pending vector
    a_r5_shared_view: assert property (@(posedge clk_i) disable iff (!rst_ni)
        line_addr |-> (rdata_o[PP +: N] == pend_w));

    // R8: nothing pending means all request lines drop next cycle
    a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_w == '0) |=> (irq_o == '0));

    for (genvar n = 0; n < N; n++) begin : g_src
        // R7: an active source is pending on the next edge
        a_r7_level_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
            act_w[n] |=> pend_w[n]);
        // R6: acknowledge of an inactive source clears it
        a_r6_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_en_i && line_addr && wdata_i[PP+n] && !act_w[n]) |=> !pend_w[n]);
    end
endmodule

bind irq_aggregator irqagg_chk #(
    .N  (NSRC),
    .L  (NLINE),
    .AW (AW),
    .DW (DW),
    .PP (PPOS)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o),
    .pol_w   (pol_w),
    .pend_w  (pend_w),
    .act_w   (act_w)
);

// File: tb/sim_irq_aggregator.sv
`timescale 1ns/1ps
module sim_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  src = 9'h1FF;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    typedef struct {
        string       req;
        bit          is_irq;
        logic [31:0] exp;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #2 clk = ~clk;

    irq_aggregator u0 (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .src_i   (src),
        .wr_en_i (wr_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    // monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            wait (sb_q.size() != 0);
            begin
                sb_item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? {29'd0, irq} : rdata;
                n_chk++;
                if (act !== it.exp) begin
                    n_err++;
                    $display("FAIL %s: actual 0x%08h expected 0x%08h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic chk_rd(input logic [3:0] a, input logic [31:0] e, input string req);
        addr = a;
        #1;
        sb_q.push_back('{req: req, is_irq: 1'b0, exp: e});
        wait (sb_q.size() == 0);
    endtask

    task automatic chk_irq(input logic [2:0] e, input string req);
        #1;
        sb_q.push_back('{req: req, is_irq: 1'b1, exp: {29'd0, e}});
        wait (sb_q.size() == 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        tick(3);
        chk_rd(4'd0, 32'h0, "R1 pol in reset");
        chk_irq(3'b000, "R1 irq in reset");
        @(negedge clk);
        rst_n = 1'b1;
        tick(5);
        for (int a = 0; a < 4; a++) chk_rd(4'(a), 32'h0, "R1 regs after reset");
        chk_irq(3'b000, "R1 irq after reset");

        // R2: polarity register, only bits [8:0]
        wr(4'd0, 32'h5A5A_A1A5);
        chk_rd(4'd0, 32'h0000_01A5, "R2 pol readback");
        // sources idle high: bits with pol=1 become pending
        wr(4'd0, 32'h0);
        tick(2);
        // R5: same pending view from all three line registers
        chk_rd(4'd1, 32'h01A5_0000, "R5 view line0");
        chk_rd(4'd2, 32'h01A5_0000, "R5 view line1");
        chk_rd(4'd3, 32'h01A5_0000, "R5 view line2");

        // R11: clear-all write to each line register
        wr(4'd1, 32'h01FF_0000);
        wr(4'd2, 32'h01FF_0000);
        wr(4'd3, 32'h01FF_0000);
        chk_rd(4'd1, 32'h0, "R11 line0 cleared");
        chk_rd(4'd3, 32'h0, "R11 line2 cleared");

        // R3: unmapped words
        wr(4'd4, 32'hFFFF_FFFF);
        wr(4'd15, 32'hFFFF_FFFF);
        chk_rd(4'd4, 32'h0, "R3 word4 reads zero");
        chk_rd(4'd15, 32'h0, "R3 word15 reads zero");
        chk_rd(4'd0, 32'h0, "R3 pol untouched");
        chk_rd(4'd2, 32'h0, "R3 line1 untouched");
        chk_irq(3'b000, "R3 irq untouched");

        // R4 active-low + R12 latency
        src[3] = 1'b0;
        tick(2);
        chk_rd(4'd1, 32'h0, "R12 not yet pending");
        tick(1);
        chk_rd(4'd1, 32'h0008_0000, "R12/R4 active-low pending");
        src[3] = 1'b1;
        tick(3);
        chk_rd(4'd2, 32'h0008_0000, "R6 held after inactive");
        wr(4'd2, 32'h0008_0000);
        chk_rd(4'd1, 32'h0, "R6 ack via line1 clears");

        // R4 active-high
        wr(4'd0, 32'h0000_0020);
        tick(1);
        chk_rd(4'd3, 32'h0020_0000, "R4 active-high pending");
        src[5] = 1'b0;
        tick(3);
        wr(4'd3, 32'h0020_0000);
        chk_rd(4'd3, 32'h0, "R6 ack active-high source");

        // R8/R9: routing by enables
        wr(4'd1, 32'h0000_0004);
        wr(4'd3, 32'h0000_0084);
        chk_irq(3'b000, "R8 no pending no irq");
        src[2] = 1'b0;
        tick(3);
        chk_irq(3'b000, "R8 irq one edge after pending");
        tick(1);
        chk_irq(3'b101, "R8 lines 0 and 2 asserted");
        chk_rd(4'd2, 32'h0004_0000, "R9 masked on line1 still pending");
        chk_rd(4'd1, 32'h0004_0004, "R5 line0 fields");
        chk_rd(4'd3, 32'h0004_0084, "R5 line2 fields");

        // R7: ack while still active
        wr(4'd1, 32'h0004_0004);
        chk_rd(4'd1, 32'h0004_0004, "R7 re-set while active");
        chk_irq(3'b101, "R7 irq stays");

        // R6: writing zeros to pending field has no effect
        wr(4'd3, 32'h0000_0084);
        chk_rd(4'd3, 32'h0004_0084, "R6 zero write keeps pending");

        // R10: atomic mask and acknowledge
        src[2] = 1'b1;
        tick(3);
        chk_irq(3'b101, "R6 latched after source idle");
        wr(4'd1, 32'h0004_0000);
        chk_irq(3'b101, "R8 irq lags by one edge");
        tick(1);
        chk_irq(3'b000, "R10 masked and acked");
        chk_rd(4'd1, 32'h0, "R10 line0 empty");
        chk_rd(4'd3, 32'h0000_0084, "R10 line2 enables kept");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule